// File: doc/BRIEF.md
# Serial Register Access Master

This block drives the host end of a four-wire register link: a serial clock, a host-to-target data line, a target-to-host data line and an active-low strobe. A request is given on a parallel port as a single-cycle start pulse with a direction flag, an 8-bit register address and a 32-bit write value. The block then produces the complete serial frame, collects the returned bits for a read, and signals completion with a one-cycle done pulse. At that point the 32-bit read result is available on a parallel output.

A read frame sends the address first and then the command bit, which is 0. It finishes with 32 clock pulses, and the target returns one bit on each pulse. A write frame sends the 32 data bits first, then the address, and then the command bit, which is 1. In both frames the command bit is the only bit sent with the strobe held low. A divider input sets how many system clocks each half of the serial clock lasts, and so sets the bit rate.

Top module: `serial_reg_master`

## Requirements
- R1: Out of reset, and whenever the block is idle, ser_strb_n is 1, ser_clk is 0, ser_dout is 0, busy is 0 and done is 0.
- R2: The high half and the low half of ser_clk each last max(half_period,1) system clocks. A frame of N pulses keeps busy high for exactly 2*max(half_period,1)*N+1 cycles, and this count includes the done cycle.
- R3: A read (wr=0) first sends the 8 address bits on ser_dout, most significant bit first. Each bit is set up while ser_clk is low and is held through the rising edge that follows.
- R4: The ninth pulse of a read carries ser_dout=0, and ser_strb_n is low for that pulse only.
- R5: A read ends with 32 further pulses. On each rising edge, ser_din is sampled into the result, most significant bit first, and ser_dout stays at 0.
- R6: A write (wr=1) sends the 32 data bits, most significant bit first, and then the 8 address bits, most significant bit first. This gives 41 pulses in all, counting the command pulse.
- R7: The final pulse of a write carries ser_dout=1, and ser_strb_n is low for that pulse only.
- R8: done is high for exactly one cycle, right after the falling edge of the last pulse. rdata then holds the value that was read.
- R9: A start that arrives while busy is high has no effect. The current frame keeps its pulse count and its bits, and no second frame follows it.
- R10: ser_dout and ser_strb_n change only while ser_clk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | DIV_W | System clocks per serial half-period (0 is treated as 1) |
| start | input | 1 | Request pulse, accepted only while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write value |
| busy | output | 1 | A frame is in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read result |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Host-to-target data |
| ser_strb_n | output | 1 | Active-low command strobe |
| ser_din | input | 1 | Target-to-host data |

## Verification
The checker watches several rules on every cycle. The line levels must be correct whenever the block is idle. Data and strobe may move only while the serial clock is low. The strobe must fall and rise only in step with the clock low phase. done must stay one cycle wide, and busy must not drop in the middle of a frame.

Some behaviour can only be shown by the bench scenarios. Each transaction is replayed through a model of the target, which records every bit and strobe level at each rising edge. This shows the bit order, the command bit value, the correct pulse counts, the half-period lengths, the total latency and the returned read value. The scenarios sweep several divider values and data patterns, and they also show that a start request during a frame has no effect.

// File: rtl/serial_reg_master.sv
module serial_reg_master #(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ser_clk,
  output logic              ser_dout,
  output logic              ser_strb_n,
  input  logic              ser_din
);
  localparam int CW = $clog2(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_ADDR, S_CMD, S_RDIN, S_DONE} state_t;

  state_t            state;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     bits;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  hp;
  logic              tick;
  logic              bit_end;

  assign hp      = (half_period == '0) ? DIV_W'(1) : half_period;
  assign tick    = (cnt == hp - DIV_W'(1));
  assign bit_end = tick && ser_clk;

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign ser_strb_n = (state != S_CMD);
  assign ser_dout   = (state == S_DATA || state == S_ADDR) ? sh[DATA_W-1] :
                      (state == S_CMD) ? wr_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      sh      <= '0;
      bits    <= '0;
      cnt     <= '0;
      ser_clk <= 1'b0;
      rdata   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt     <= '0;
          ser_clk <= 1'b0;
          if (start) begin
            wr_q   <= wr;
            addr_q <= addr;
            if (wr) begin
              state <= S_DATA;
              sh    <= wdata;
              bits  <= CW'(DATA_W - 1);
            end else begin
              state <= S_ADDR;
              sh    <= {addr, {(DATA_W-ADDR_W){1'b0}}};
              bits  <= CW'(ADDR_W - 1);
            end
          end
        end
        S_DONE: state <= S_IDLE;
        default: begin
          cnt <= tick ? '0 : cnt + DIV_W'(1);
          if (tick) ser_clk <= ~ser_clk;
          if (tick && !ser_clk && state == S_RDIN)
            rdata <= {rdata[DATA_W-2:0], ser_din};
          if (bit_end) begin
            if (bits != '0) begin
              bits <= bits - CW'(1);
              sh   <= {sh[DATA_W-2:0], 1'b0};
            end else begin
              case (state)
                S_DATA: begin
                  state <= S_ADDR;
                  sh    <= {addr_q, {(DATA_W-ADDR_W){1'b0}}};
                  bits  <= CW'(ADDR_W - 1);
                end
                S_ADDR: state <= S_CMD;
                S_CMD: begin
                  state <= wr_q ? S_DONE : S_RDIN;
                  bits  <= CW'(DATA_W - 1);
                end
                default: state <= S_DONE;
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_reg_master_chk.sv
module serial_reg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_strb_n
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && ser_strb_n && !ser_dout && !done));

  assert_dout_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> ($stable(ser_dout) && $stable(ser_strb_n)));

  assert_strobe_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_strb_n) |-> !ser_clk);

  assert_strobe_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_strb_n) |-> $fell(ser_clk));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind serial_reg_master serial_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_strb_n(ser_strb_n)
);

// File: tb/tb_serial_reg_master.sv
module tb_serial_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_period = 8'd1;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        busy, done, ser_clk, ser_dout, ser_strb_n;
  logic [31:0] rdata;
  logic        ser_din = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int np = 0;
  int t_r = 0, t_f = 0;
  int hi_err = 0;
  int ridx = 0;
  int hexp = 1;
  logic        log_d [0:63];
  logic        log_s [0:63];
  logic [31:0] rd_val = '0;

  serial_reg_master dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .start(start), .wr(wr),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_strb_n(ser_strb_n), .ser_din(ser_din)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc++;

  always @(posedge ser_clk) begin
    if (np > 0 && (cyc - t_f) != hexp) hi_err++;
    t_r = cyc;
    if (np < 64) begin
      log_d[np] = ser_dout;
      log_s[np] = ser_strb_n;
    end
    np++;
  end

  always @(negedge ser_clk) begin
    t_f = cyc;
    if ((cyc - t_r) != hexp) hi_err++;
    if (np > 0 && np <= 64 && !log_s[np-1] && !log_d[np-1]) begin
      ridx = 31;
      ser_din = rd_val[31];
    end else if (ridx > 0) begin
      ridx--;
      ser_din = rd_val[ridx];
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] rv, input bit poke);
    int nb, dn, npulse;
    rd_val = rv;
    ridx = 0;
    np = 0;
    hi_err = 0;
    nb = 0;
    dn = 0;
    npulse = w ? 41 : 41;
    @(negedge clk);
    start = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    nb = busy ? 1 : 0;
    while (busy) begin
      if (done) dn++;
      if (poke && nb == 7) begin
        start = 1'b1; wr = ~w; addr = ~a; wdata = ~d;
      end else start = 1'b0;
      @(negedge clk);
      if (busy) nb++;
    end
    start = 1'b0;
    check(np == npulse, "R6/R9 pulse count", np, npulse);
    check(nb == 2 * hexp * npulse + 1, "R2 busy length", nb, 2 * hexp * npulse + 1);
    check(hi_err == 0, "R2 half-period length", hi_err, 0);
    check(dn == 1, "R8 done width", dn, 1);
    if (w) begin
      int bad = 0;
      for (int i = 0; i < 32; i++) if (log_d[i] !== d[31-i] || !log_s[i]) bad++;
      check(bad == 0, "R6 data bits", bad, 0);
      bad = 0;
      for (int i = 0; i < 8; i++) if (log_d[32+i] !== a[7-i] || !log_s[32+i]) bad++;
      check(bad == 0, "R6 address bits", bad, 0);
      check(log_d[40] === 1'b1 && log_s[40] === 1'b0, "R7 write command", {log_d[40], log_s[40]}, 2'b10);
    end else begin
      int bad = 0;
      for (int i = 0; i < 8; i++) if (log_d[i] !== a[7-i] || !log_s[i]) bad++;
      check(bad == 0, "R3 address bits", bad, 0);
      check(log_d[8] === 1'b0 && log_s[8] === 1'b0, "R4 read command", {log_d[8], log_s[8]}, 2'b00);
      bad = 0;
      for (int i = 9; i < 41; i++) if (log_d[i] !== 1'b0 || !log_s[i]) bad++;
      check(bad == 0, "R5 dout idle during read-in", bad, 0);
      check(rdata == rv, "R5/R8 read result", rdata, rv);
    end
    repeat (3 * hexp + 2) @(negedge clk);
    check(np == npulse && !busy, "R9 no second frame", np, npulse);
    check(!ser_clk && ser_strb_n && !ser_dout && !done, "R1 idle lines",
          {ser_clk, ser_strb_n, ser_dout, done}, 4'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !ser_clk && ser_strb_n && !ser_dout, "R1 reset state",
          {busy, done, ser_clk, ser_strb_n, ser_dout}, 5'b00010);
    rst_n = 1'b1;
    for (int h = 0; h <= 3; h++) begin
      half_period = 8'(h);
      hexp = (h == 0) ? 1 : h;
      run(1'b1, 8'h80, 32'hA5C3_0F71, 32'h0, 1'b0);
      run(1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b0);
      run(1'b1, 8'hFF, 32'h0000_0001, 32'h0, 1'b0);
      run(1'b0, 8'h02, 32'h0, 32'hDEAD_BEEF, 1'b0);
      run(1'b0, 8'hFF, 32'h0, 32'h8000_0001, 1'b0);
      run(1'b0, 8'h5A, 32'h0, 32'h0, 1'b0);
      run(1'b0, 8'h08, 32'h0, 32'hFFFF_FFFF, 1'b1);
      run(1'b1, 8'h3C, 32'h1234_5678, 32'h0, 1'b1);
    end
    for (int k = 0; k < 32; k++) begin
      half_period = 8'd1;
      hexp = 1;
      run(1'b0, 8'(k * 7), 32'h0, 32'h1 << k, 1'b0);
      run(1'b1, 8'(1 << (k % 8)), 32'h1 << k, 32'h0, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule